// File: doc/BRIEF.md
# Square-Root Carry-Select Adder with Increment Converters

This block is a purely combinational adder. It takes two operands and a carry input, and it returns the sum and the carry out. The operand width is set by `WIDTH`, which defaults to 16. The datapath is divided into groups whose widths grow along a square-root schedule: the first two groups are two bits wide, and each later group is one bit wider than the group below it. Any bits left over are folded into the top group. At the default width the groups cover bits [1:0], [3:2], [6:4], [10:7] and [15:11].

Each group works the same way:

- A ripple adder forms the group result for carry-in 0. Its lowest stage is a half adder.
- An increment-by-one converter, one bit wider than the group, forms the carry-in-1 result. Its input is the carry-in-0 sum together with that adder's carry out.
- A 2:1 multiplexer picks one of the two results. It is one bit wider than the group and carries the group carry-out along with the sum bits.
- The multiplexer select is the carry out of the group below. For the lowest group, the select is the external carry input.

The longest path runs through the chain of group-carry multiplexers.

Top module: `sqcsa_top`

## Requirements
- R1: For every input, {cout, sum} equals the (WIDTH+1)-bit value opa + opb + cin. This includes the all-zero input, which gives an all-zero output.
- R2: With opa = 0 and opb = 0, sum equals cin in bit 0 with zeros above it, and cout is 0.
- R3: With opb = 0, {cout, sum} equals opa + cin. In particular, opa all ones with cin = 1 gives sum = 0 and cout = 1.
- R4: With opa and opb both all ones, sum equals all ones minus 1 plus cin, and cout is 1.
- R5: The carry into every group lower boundary (bit positions 2, 4, 7 and 11 at the default width) equals the carry out of the arithmetic sum of all bits below that boundary plus cin.
- R6: cout is 1 exactly when opa + opb + cin is at least 2^WIDTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| cin | input | 1 | Carry input; selects the result of the lowest group |
| sum | output | WIDTH | Sum bits |
| cout | output | 1 | Carry out of the top group |

## Verification
The bench builds the adder at the default `WIDTH` of 16. At that width the five-group schedule 2, 2, 3, 4, 5 fills the datapath exactly, so no remainder is folded into the top group. At this size every group boundary can be reached with a directed operand that places a run of ones just below the boundary. The bench also sweeps a ones-run plus cin across every bit position, so a carry has to travel through each select multiplexer in the chain. All-ones operands and alternating patterns exercise the propagate cases in every group, and random operands with a random cin cover the full arithmetic relation.

// File: rtl/sqcsa_pkg.sv
// Package: shared group-schedule arithmetic for the carry-select adder.
// Assumes width >= 2. Group 0 is two bits wide and group g (g >= 1) is
// g+1 bits wide; any leftover bits are folded into the last group.
package sqcsa_pkg;

    // Number of groups the schedule yields for a given width.
    function automatic int grp_count(input int width);
        int used;
        int n;
        used = 2;
        n    = 1;
        while (used + n + 1 <= width) begin
            used = used + n + 1;
            n    = n + 1;
        end
        return n;
    endfunction

    // Lowest bit index of group g.
    function automatic int grp_lo(input int width, input int g);
        int lo;
        lo = (g > 0 && width > 0) ? 2 : 0;
        for (int j = 1; j < g; j++) lo = lo + j + 1;
        return lo;
    endfunction

    // Width of group g; the last group takes whatever bits remain.
    function automatic int grp_w(input int width, input int g);
        if (g == grp_count(width) - 1) return width - grp_lo(width, g);
        return (g == 0) ? 2 : g + 1;
    endfunction

endpackage

// File: rtl/sqcsa_rca.sv
// Module: ripple adder for the carry-in-0 case of one group.
// Bit 0 is a half adder and every higher bit is a full adder.
// Assumes W >= 1. Purely combinational.
module sqcsa_rca #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] s,
    output logic         co
);
    logic [W:0] c;

    // Ripple chain: half adder at bit 0, then a full adder per bit.
    always_comb begin
        c    = '0;
        s    = '0;
        s[0] = a[0] ^ b[0];
        c[1] = a[0] & b[0];
        for (int i = 1; i < W; i++) begin
            s[i]   = a[i] ^ b[i] ^ c[i];
            c[i+1] = (a[i] & b[i]) | (c[i] & (a[i] ^ b[i]));
        end
        co = c[W];
    end
endmodule

// File: rtl/sqcsa_bec.sv
// Module: increment-by-one converter of N bits (x = v + 1 modulo 2^N).
// Bit i toggles when every bit below it is one, and bit 0 always toggles.
// Assumes N >= 2. Purely combinational.
module sqcsa_bec #(
    parameter int N = 5
) (
    input  logic [N-1:0] v,
    output logic [N-1:0] x
);
    logic [N-1:0] ones_below;

    // Build the AND prefix, then flip each bit whose lower bits are all one.
    always_comb begin
        ones_below[0] = 1'b1;
        for (int i = 1; i < N; i++) ones_below[i] = ones_below[i-1] & v[i-1];
        x = v ^ ones_below;
    end
endmodule

// File: rtl/sqcsa_group.sv
// Module: one carry-select group. It forms the carry-in-0 result with a
// ripple adder and derives the carry-in-1 result by incrementing it. The
// incoming group carry then selects between the two (W+1 bits, so the
// carry out is chosen together with the sum).
// Assumes W >= 1. Purely combinational.
module sqcsa_group #(
    parameter int W = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sel,
    output logic [W-1:0] s,
    output logic         co
);
    localparam int N = W + 1;

    logic [W-1:0] s_zero;
    logic         c_zero;
    logic [N-1:0] inc;

    sqcsa_rca #(.W(W)) u_rca (
        .a  (a),
        .b  (b),
        .s  (s_zero),
        .co (c_zero)
    );

    sqcsa_bec #(.N(N)) u_bec (
        .v ({c_zero, s_zero}),
        .x (inc)
    );

    // Carry-select multiplexer over sum and carry together.
    always_comb begin
        {co, s} = sel ? inc : {c_zero, s_zero};
    end
endmodule

// File: rtl/sqcsa_top.sv
// Module: square-root carry-select adder, {cout, sum} = opa + opb + cin.
// The groups are laid out by sqcsa_pkg. The select for group g is
// grp_carry[g], with grp_carry[0] = cin. Purely combinational: there is
// no clock or reset.
module sqcsa_top #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] opa,
    input  logic [WIDTH-1:0] opb,
    input  logic             cin,
    output logic [WIDTH-1:0] sum,
    output logic             cout
);
    import sqcsa_pkg::*;

    localparam int NGRP = grp_count(WIDTH);

    logic [NGRP:0] grp_carry;

    // The external carry drives the first select.
    assign grp_carry[0] = cin;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        localparam int LO = grp_lo(WIDTH, g);
        localparam int GW = grp_w(WIDTH, g);
        sqcsa_group #(.W(GW)) u_group (
            .a   (opa[LO +: GW]),
            .b   (opb[LO +: GW]),
            .sel (grp_carry[g]),
            .s   (sum[LO +: GW]),
            .co  (grp_carry[g+1])
        );
    end

    // The carry out of the top group is the adder carry out.
    assign cout = grp_carry[NGRP];
endmodule

// File: rtl/sqcsa_chk.sv
// Checker: arithmetic properties of sqcsa_top, attached with bind.
// These are immediate assertions on settled combinational values.
module sqcsa_chk #(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0] opa,
    input logic [WIDTH-1:0] opb,
    input logic             cin,
    input logic [WIDTH-1:0] sum,
    input logic             cout,
    input logic [sqcsa_pkg::grp_count(WIDTH):0] grp_carry
);
    import sqcsa_pkg::*;

    localparam int NGRP = grp_count(WIDTH);

    logic [WIDTH:0] full;

    // Reference sum built from the ports.
    always_comb begin
        full = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, cin};
    end

    // Full result, zero operands, increment, all-ones operands and carry out.
    always_comb begin
        p_full_sum_r1: assert ({cout, sum} == full)
            else $error("R1 result mismatch");
        if (opa == '0 && opb == '0) begin
            p_zero_ops_r2: assert (sum == {{(WIDTH-1){1'b0}}, cin} && !cout)
                else $error("R2 zero operand case");
        end
        if (opb == '0) begin
            p_increment_r3: assert ({cout, sum} == ({1'b0, opa} + {{WIDTH{1'b0}}, cin}))
                else $error("R3 increment case");
        end
        if (opa == '1 && opb == '1) begin
            p_all_ones_r4: assert (cout && sum == ({WIDTH{1'b1}} - WIDTH'(1) + WIDTH'(cin)))
                else $error("R4 all-ones case");
        end
        p_carry_out_r6: assert (cout == (full >= (WIDTH+1)'(1) << WIDTH))
            else $error("R6 carry out");
    end

    // Carry into each upper group matches the arithmetic of all lower bits.
    for (genvar g = 1; g < NGRP; g++) begin : g_bnd
        localparam int LO = grp_lo(WIDTH, g);
        logic [LO:0] low_sum;
        always_comb begin
            low_sum = {1'b0, opa[LO-1:0]} + {1'b0, opb[LO-1:0]} + {{LO{1'b0}}, cin};
            p_group_carry_r5: assert (grp_carry[g] == low_sum[LO])
                else $error("R5 group carry");
        end
    end
endmodule

bind sqcsa_top sqcsa_chk #(.WIDTH(WIDTH)) u_chk (
    .opa       (opa),
    .opb       (opb),
    .cin       (cin),
    .sum       (sum),
    .cout      (cout),
    .grp_carry (grp_carry)
);

// File: tb/sqcsa_top_tb.sv
// Bench for sqcsa_top. It walks a vector table, then a boundary sweep,
// random vectors and a reset-phase check.
module sqcsa_top_tb;
    localparam int  CLK_PERIOD = 10;
    localparam int  WIDTH      = 16;
    localparam int  NVEC       = 14;
    localparam int  NRAND      = 2000;

    // Vector fields: {opa, opb, cin, expected {cout, sum}}.
    localparam logic [49:0] VECS [NVEC] = '{
        {16'h0000, 16'h0000, 1'b0, 17'h00000},  // R1
        {16'h0000, 16'h0000, 1'b1, 17'h00001},  // R2
        {16'hFFFF, 16'h0000, 1'b1, 17'h10000},  // R3
        {16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF},  // R4
        {16'hFFFF, 16'hFFFF, 1'b0, 17'h1FFFE},  // R4
        {16'h0003, 16'h0001, 1'b0, 17'h00004},  // R5 bit 2
        {16'h000F, 16'h0001, 1'b0, 17'h00010},  // R5 bit 4
        {16'h007F, 16'h0000, 1'b1, 17'h00080},  // R5 bit 7
        {16'h07FF, 16'h0001, 1'b0, 17'h00800},  // R5 bit 11
        {16'h8000, 16'h8000, 1'b0, 17'h10000},  // R6
        {16'h1234, 16'h4321, 1'b0, 17'h05555},  // R1
        {16'h7FFF, 16'h8000, 1'b1, 17'h10000},  // R6
        {16'hAAAA, 16'h5555, 1'b0, 17'h0FFFF},  // R6
        {16'hAAAA, 16'h5555, 1'b1, 17'h10000}   // R6
    };

    logic             clk;
    logic             rst_n;
    logic [WIDTH-1:0] opa;
    logic [WIDTH-1:0] opb;
    logic             cin;
    logic [WIDTH-1:0] sum;
    logic             cout;
    int               checks;
    int               failures;
    bit               done;

    sqcsa_top #(.WIDTH(WIDTH)) u_dut (
        .opa  (opa),
        .opb  (opb),
        .cin  (cin),
        .sum  (sum),
        .cout (cout)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    // Compare the sampled {cout, sum} with the expected value; print on a mismatch.
    task automatic check(input string req, input logic [WIDTH:0] exp);
        checks++;
        if ({cout, sum} !== exp) begin
            failures++;
            $display("FAIL %s opa=%h opb=%h cin=%b got=%h exp=%h",
                     req, opa, opb, cin, {cout, sum}, exp);
        end
    endtask

    // Drive on the falling edge and sample just after the rising edge.
    task automatic apply(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b,
                         input logic c, input string req,
                         input logic [WIDTH:0] exp);
        @(negedge clk);
        opa = a;
        opb = b;
        cin = c;
        @(posedge clk);
        #1;
        check(req, exp);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        checks   = 0;
        failures = 0;
        done     = 1'b0;
        rst_n    = 1'b0;
        opa      = '0;
        opb      = '0;
        cin      = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset phase zero", '0);
        rst_n = 1'b1;

        // Table walk.
        for (int i = 0; i < NVEC; i++) begin
            apply(VECS[i][49:34], VECS[i][33:18], VECS[i][17], "R1 table",
                  VECS[i][16:0]);
        end

        // R5 and R3: a ones-run below bit k plus cin = 1 carries into bit k.
        for (int k = 1; k <= WIDTH; k++) begin
            logic [WIDTH:0] one_k;
            one_k = (WIDTH+1)'(1) << k;
            apply(WIDTH'(one_k - 1), '0, 1'b1, "R5 boundary sweep", one_k);
        end

        // R5 and R6: the run in opa, with opb = 1 and cin = 0.
        for (int k = 1; k <= WIDTH; k++) begin
            logic [WIDTH:0] one_k;
            one_k = (WIDTH+1)'(1) << k;
            apply(WIDTH'(one_k - 1), WIDTH'(1), 1'b0, "R6 carry chain", one_k);
        end

        // R1: random operands checked against a behavioural sum.
        for (int i = 0; i < NRAND; i++) begin
            logic [WIDTH-1:0] ra;
            logic [WIDTH-1:0] rb;
            logic             rc;
            ra = WIDTH'($urandom);
            rb = WIDTH'($urandom);
            rc = 1'($urandom);
            apply(ra, rb, rc, "R1 random",
                  {1'b0, ra} + {1'b0, rb} + {{WIDTH{1'b0}}, rc});
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule